// File: doc/BRIEF.md
# Serial NOR Flash Command Interpreter

This block acts as the device side of a serial NOR flash at byte level. Each transaction is framed by an active-low select. The first byte is an opcode. Some opcodes take an address of three or four bytes, sent most significant byte first. Data bytes follow, either written in through `in_valid`/`in_byte` or pulled out one at a time through `out_req`/`out_valid`/`out_byte`. Bit shifting is left to a separate serializer in front of the block. This block only sees whole bytes.

Internally it holds a byte array of `2**MEM_AW` entries, erased to 0xFF at reset, plus a write-enable latch, a busy flag and an address-width flag. Programming can only clear bits, and it stays within one page. Erases of three region sizes, and of the whole array, are carried out by a fill engine that writes 0xFF into one byte per clock. Protocol violations raise a one-cycle `err` pulse on the cycle after the offending byte or request.

Top module: `nor_flash_emu`

## Requirements
- R1: After reset the status byte reads 0x00, the address width is three bytes, every array byte reads 0xFF, and `out_valid` and `err` are low.
- R2: A status read (opcode 0x05) returns {6'b0, latch, busy}, with the busy flag in bit 0 and the write-enable latch in bit 1. Opcode 0x06 sets the latch and opcode 0x04 clears it.
- R3: Identification (opcode 0x9F) returns 0x55, 0xAA and 0x55 for the first three requested bytes, and 0x00 for every later byte.
- R4: Opcodes 0x03, 0x02, 0x20, 0x52 and 0xD8 collect the address most significant byte first. They take three bytes by default, and four bytes after opcode 0xB7 until opcode 0xE9.
- R5: A read (opcode 0x03) returns the array byte at the address and then increments the address. Each `out_valid` pulse comes exactly one cycle after the `out_req` it answers.
- R6: Each page-program (opcode 0x02) data byte is ANDed into the array. The low PAGE_AW address bits then increment and wrap, while the upper address bits stay fixed.
- R7: When the latch is clear, program, erase and chip-erase (opcode 0x60) are ignored. The array and the status byte are left unchanged and `err` stays low.
- R8: When select rises after a program has entered its data phase, the busy flag is set and the latch is cleared.
- R9: Opcodes 0x20, 0x52 and 0xD8 fill the aligned region containing the address with 0xFF. The region sizes are 2**SEC_AW, 2**B32_AW and 2**B64_AW bytes respectively, clipped to the array. Opcode 0x60 fills the whole array. When an erase starts, the busy flag is set and the latch is cleared.
- R10: An erase writes one byte per clock. While it runs, the busy flag stays set. Any program or erase opcode received during an erase raises `err` and is ignored.
- R11: A status read returns the current status byte and then clears the busy flag, provided no erase is running.
- R12: Each of the following pulses `err`: an unknown opcode; a byte sent in a phase that takes no input (identify, status, read data, or after a no-payload opcode); `out_req` in a phase that has no output; and `in_valid` while select is high.
- R13: A read byte at an address at or beyond the array end returns 0x00 and pulses `err`. A program or erase whose address lies beyond the array end pulses `err` on the final address byte and is ignored.
- R14: Raising select returns the interpreter to waiting for an opcode, even in the middle of an address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transaction select |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input byte (opcode, address or data) |
| out_req | input | 1 | Request for one output byte |
| out_valid | output | 1 | Output byte valid, one cycle after the request |
| out_byte | output | 8 | Returned byte |
| err | output | 1 | One-cycle protocol violation pulse |

## Verification
The bench builds the block with MEM_AW=10 and PAGE_AW=8, and shrinks the erase regions to SEC_AW=6, B32_AW=7 and B64_AW=8. This gives three distinct erase sizes of 64, 128 and 256 bytes, all inside a 1 KiB array. As a result, aligned region boundaries, clipping at the array end and a full chip erase all run within about a thousand cycles. The small array also lets reads run off its end, and lets out-of-range addresses be reached in both 3-byte and 4-byte address modes. Random programs and erases are checked against a byte model kept in the bench.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDST  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_SE    = 8'h20;
  localparam logic [7:0] OP_BE32  = 8'h52;
  localparam logic [7:0] OP_BE64  = 8'hD8;
  localparam logic [7:0] OP_CE    = 8'h60;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_A4ON  = 8'hB7;
  localparam logic [7:0] OP_A4OFF = 8'hE9;

  typedef enum logic [3:0] {
    PH_CMD, PH_ID, PH_STAT, PH_RADDR, PH_RDATA,
    PH_PADDR, PH_PDATA, PH_EADDR, PH_END, PH_SINK
  } phase_t;

  // next program address: low page bits wrap, upper bits held
  function automatic logic [31:0] page_step(input logic [31:0] a, input int unsigned page_aw);
    logic [31:0] m;
    m = (32'd1 << page_aw) - 32'd1;
    return (a & ~m) | ((a + 32'd1) & m);
  endfunction

  function automatic logic [31:0] region_first(input logic [31:0] a, input int unsigned lg);
    return a & ~((32'd1 << lg) - 32'd1);
  endfunction

  function automatic logic [31:0] region_last(input logic [31:0] a, input int unsigned lg,
                                               input logic [31:0] lim);
    logic [31:0] e;
    e = region_first(a, lg) + ((32'd1 << lg) - 32'd1);
    if (e >= lim) e = lim - 32'd1;
    return e;
  endfunction

  function automatic logic in_range(input logic [31:0] a, input logic [31:0] lim);
    return a < lim;
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h55;
      3'd1:    return 8'hAA;
      3'd2:    return 8'h55;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nfe_fill.sv
module nfe_fill #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic          active,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);
  logic [AW-1:0] cur_q, end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur_q  <= '0;
      end_q  <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      cur_q  <= first;
      end_q  <= last;
    end else if (active) begin
      if (cur_q == end_q) active <= 1'b0;
      else cur_q <= cur_q + 1'b1;
    end
  end

  assign wr_en   = active;
  assign wr_addr = cur_q;

  p_fill_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cur_q != end_q) |=> (active && cur_q == AW'($past(cur_q) + 1'b1)));
  p_fill_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cur_q == end_q) |=> !active);
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
endmodule

// File: rtl/nfe_array.sv
module nfe_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (fill_we) begin
      mem_q[fill_addr] <= 8'hFF;
    end else if (prog_we) begin
      mem_q[prog_addr] <= mem_q[prog_addr] & prog_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  p_single_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_we && fill_we));
endmodule

// File: rtl/nor_flash_emu.sv
module nor_flash_emu import nfe_pkg::*; #(
  parameter int MEM_AW  = 10,
  parameter int PAGE_AW = 8,
  parameter int SEC_AW  = 12,
  parameter int B32_AW  = 15,
  parameter int B64_AW  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       out_req,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       err
);
  localparam logic [31:0] MEM_BYTES = 32'd1 << MEM_AW;

  phase_t      phase_q, phase_d;
  logic [2:0]  idx_q, idx_d;
  logic [31:0] addr_q, addr_d;
  logic [1:0]  esel_q, esel_d;
  logic        wel_q, wel_d, wip_q, wip_d, a4_q, a4_d;

  // named events for the assertions
  logic              prog_we, fill_start, fill_busy, prog_done;
  logic              ev_err_in, ev_err_out, out_ok;
  logic [7:0]        out_d, rd_data;
  logic [MEM_AW-1:0] fill_first, fill_last;
  logic              fill_we;
  logic [MEM_AW-1:0] fill_addr;

  logic [2:0]  asize;
  logic        addr_done;
  logic [31:0] addr_next;

  assign asize     = a4_q ? 3'd4 : 3'd3;
  assign addr_done = (idx_q + 3'd1) == asize;
  assign addr_next = {addr_q[23:0], in_byte};

  always_comb begin
    int unsigned lg;
    lg = (esel_q == 2'd1) ? B32_AW : (esel_q == 2'd2) ? B64_AW : SEC_AW;
    phase_d = phase_q; idx_d = idx_q; addr_d = addr_q; esel_d = esel_q;
    wel_d = wel_q; wip_d = wip_q; a4_d = a4_q;
    prog_we = 1'b0; fill_start = 1'b0; prog_done = 1'b0;
    fill_first = '0; fill_last = '0;
    ev_err_in = 1'b0; ev_err_out = 1'b0; out_ok = 1'b0; out_d = 8'h00;
    if (cs_n) begin
      phase_d = PH_CMD;
      if (phase_q == PH_PDATA) begin
        prog_done = 1'b1; wip_d = 1'b1; wel_d = 1'b0;
      end
      ev_err_in  = in_valid;
      ev_err_out = out_req;
    end else if (in_valid) begin
      ev_err_out = out_req;
      case (phase_q)
        PH_CMD: begin
          idx_d = '0; addr_d = '0; phase_d = PH_END;
          case (in_byte)
            OP_RDID:  phase_d = PH_ID;
            OP_RDST:  phase_d = PH_STAT;
            OP_READ:  phase_d = PH_RADDR;
            OP_WREN:  wel_d = 1'b1;
            OP_WRDI:  wel_d = 1'b0;
            OP_A4ON:  a4_d = 1'b1;
            OP_A4OFF: a4_d = 1'b0;
            OP_PROG, OP_SE, OP_BE32, OP_BE64: begin
              esel_d = (in_byte == OP_BE32) ? 2'd1 : (in_byte == OP_BE64) ? 2'd2 : 2'd0;
              if (fill_busy) begin
                ev_err_in = 1'b1; phase_d = PH_SINK;
              end else if (!wel_q) phase_d = PH_SINK;
              else phase_d = (in_byte == OP_PROG) ? PH_PADDR : PH_EADDR;
            end
            OP_CE: begin
              if (fill_busy) ev_err_in = 1'b1;
              else if (wel_q) begin
                fill_start = 1'b1; fill_first = '0; fill_last = '1;
                wip_d = 1'b1; wel_d = 1'b0;
              end
            end
            default: begin
              ev_err_in = 1'b1; phase_d = PH_SINK;
            end
          endcase
        end
        PH_RADDR, PH_PADDR, PH_EADDR: begin
          addr_d = addr_next;
          idx_d  = idx_q + 3'd1;
          if (addr_done) begin
            idx_d = '0;
            if (phase_q == PH_RADDR) phase_d = PH_RDATA;
            else if (!in_range(addr_next, MEM_BYTES)) begin
              ev_err_in = 1'b1; phase_d = PH_SINK;
            end else if (phase_q == PH_PADDR) phase_d = PH_PDATA;
            else begin
              fill_start = 1'b1;
              fill_first = MEM_AW'(region_first(addr_next, lg));
              fill_last  = MEM_AW'(region_last(addr_next, lg, MEM_BYTES));
              wip_d = 1'b1; wel_d = 1'b0; phase_d = PH_END;
            end
          end
        end
        PH_PDATA: begin
          prog_we = 1'b1;
          addr_d  = page_step(addr_q, PAGE_AW);
        end
        PH_SINK: ;
        default: ev_err_in = 1'b1;
      endcase
    end else if (out_req) begin
      case (phase_q)
        PH_ID: begin
          out_ok = 1'b1; out_d = id_byte(idx_q);
          if (idx_q != 3'd3) idx_d = idx_q + 3'd1;
        end
        PH_STAT: begin
          out_ok = 1'b1; out_d = {6'b0, wel_q, wip_q};
          if (!fill_busy) wip_d = 1'b0;
        end
        PH_RDATA: begin
          out_ok = 1'b1; addr_d = addr_q + 32'd1;
          if (in_range(addr_q, MEM_BYTES)) out_d = rd_data;
          else ev_err_out = 1'b1;
        end
        default: ev_err_out = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD; idx_q <= '0; addr_q <= '0; esel_q <= '0;
      wel_q <= 1'b0; wip_q <= 1'b0; a4_q <= 1'b0;
      out_valid <= 1'b0; out_byte <= 8'h00; err <= 1'b0;
    end else begin
      phase_q <= phase_d; idx_q <= idx_d; addr_q <= addr_d; esel_q <= esel_d;
      wel_q <= wel_d; wip_q <= wip_d; a4_q <= a4_d;
      out_valid <= out_ok; out_byte <= out_d; err <= ev_err_in | ev_err_out;
    end
  end

  nfe_fill #(.AW(MEM_AW)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(fill_start), .first(fill_first), .last(fill_last),
    .active(fill_busy), .wr_en(fill_we), .wr_addr(fill_addr)
  );

  nfe_array #(.AW(MEM_AW)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(addr_q[MEM_AW-1:0]),
    .prog_data(in_byte), .fill_we(fill_we), .fill_addr(fill_addr),
    .rd_addr(addr_q[MEM_AW-1:0]), .rd_data(rd_data)
  );

  p_idle_after_cs_r14: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase_q == PH_CMD));
  p_prog_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (wip_q && !wel_q));
  p_fill_holds_wip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> wip_q);
  p_out_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(out_req));
  p_prog_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> wel_q);
  p_fill_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |-> wel_q);
  p_erase_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |=> (wip_q && !wel_q && fill_busy));
endmodule

// File: tb/test_nor_flash_emu.sv
module test_nor_flash_emu;
  localparam int MEM_AW = 10, PAGE_AW = 8, SEC_AW = 6, B32_AW = 7, B64_AW = 8;
  localparam int MEM = 1 << MEM_AW;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, in_valid = 1'b0, out_req = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_valid, err;
  logic [7:0] out_byte;

  always #4 clk = ~clk;

  nor_flash_emu #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .SEC_AW(SEC_AW),
                  .B32_AW(B32_AW), .B64_AW(B64_AW)) i_nor_flash_emu (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_req(out_req), .out_valid(out_valid), .out_byte(out_byte), .err(err)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] model [MEM];
  logic [7:0] pbuf [64];
  bit b_a4 = 0, m_wel = 0, m_wip = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] b_page_next(input logic [31:0] a);
    logic [7:0] lo;
    lo = a[7:0] + 8'd1;
    return {a[31:8], lo};
  endfunction

  task automatic sel();   cs_n = 1'b0; @(negedge clk); endtask
  task automatic desel(); cs_n = 1'b1; @(negedge clk); endtask

  task automatic put(input logic [7:0] b, output logic er);
    in_valid = 1'b1; in_byte = b; @(negedge clk); in_valid = 1'b0; er = err;
  endtask

  task automatic take(output logic [7:0] d, output logic vl, output logic er);
    out_req = 1'b1; @(negedge clk); out_req = 1'b0; d = out_byte; vl = out_valid; er = err;
  endtask

  task automatic put_addr(input logic [31:0] a, output logic er);
    if (b_a4) put(a[31:24], er);
    put(a[23:16], er); put(a[15:8], er); put(a[7:0], er);
  endtask

  task automatic simple(input logic [7:0] op, input string req);
    logic er;
    sel(); put(op, er); desel();
    chk(req, "no err on opcode", er, 0);
  endtask

  task automatic status_chk(input logic [7:0] exp, input string req);
    logic er, vl; logic [7:0] s;
    sel(); put(8'h05, er); take(s, vl, er); desel();
    chk(req, "status byte", s, exp);
  endtask

  task automatic read_chk(input logic [31:0] a, input int n, input string req);
    logic er, vl; logic [7:0] d;
    sel(); put(8'h03, er); put_addr(a, er);
    for (int k = 0; k < n && (a + k) < MEM; k++) begin
      take(d, vl, er);
      chk(req, "read byte", {vl, er, d}, {1'b1, 1'b0, model[a + k]});
    end
    desel();
  endtask

  task automatic program_buf(input logic [31:0] a, input int n);
    logic er; logic [31:0] pa; bit live;
    live = m_wel && (a < MEM);
    sel(); put(8'h02, er); put_addr(a, er);
    pa = a;
    for (int k = 0; k < n; k++) begin
      put(pbuf[k], er);
      if (live) begin
        model[pa] = model[pa] & pbuf[k];
        pa = b_page_next(pa);
      end
    end
    desel();
    if (live) begin m_wip = 1; m_wel = 0; end
  endtask

  task automatic erase(input logic [7:0] op, input logic [31:0] a, output logic er);
    int lg; int lo, hi;
    lg = (op == 8'h20) ? SEC_AW : (op == 8'h52) ? B32_AW : (op == 8'hD8) ? B64_AW : MEM_AW;
    sel(); put(op, er);
    if (op != 8'h60) put_addr(a, er);
    desel();
    if (m_wel && a < MEM) begin
      lo = (int'(a) >> lg) << lg;
      hi = lo + (1 << lg);
      if (hi > MEM) hi = MEM;
      for (int i = lo; i < hi; i++) model[i] = 8'hFF;
      m_wip = 1; m_wel = 0;
    end
  endtask

  task automatic wren(); simple(8'h06, "R2"); m_wel = 1; endtask

  task automatic clear_busy(input string req);
    status_chk({6'b0, m_wel, 1'b1}, req);
    m_wip = 0;
    status_chk({6'b0, m_wel, 1'b0}, "R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic er, vl; logic [7:0] d; int unsigned sd;
    sd = $urandom(32'd2024);
    for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid/err after reset", {out_valid, err}, 0);
    status_chk(8'h00, "R1");
    read_chk(32'h0, 4, "R1");

    // identification
    sel(); put(8'h9F, er);
    take(d, vl, er); chk("R3", "id0", d, 8'h55);
    take(d, vl, er); chk("R3", "id1", d, 8'hAA);
    take(d, vl, er); chk("R3", "id2", d, 8'h55);
    take(d, vl, er); chk("R3", "id3", d, 8'h00);
    take(d, vl, er); chk("R3", "id4", d, 8'h00);
    desel();

    // program without latch is ignored
    pbuf[0] = 8'h00;
    program_buf(32'h10, 1);
    read_chk(32'h10, 1, "R7");
    status_chk(8'h00, "R7");

    // latch set and clear
    wren(); status_chk(8'h02, "R2");
    simple(8'h04, "R2"); m_wel = 0; status_chk(8'h00, "R2");

    // AND programming and completion at select release
    wren(); pbuf[0] = 8'hF0; program_buf(32'h10, 1);
    status_chk(8'h01, "R8"); m_wip = 0;
    status_chk(8'h00, "R11");
    wren(); pbuf[0] = 8'h3C; program_buf(32'h10, 1); clear_busy("R8");
    read_chk(32'h10, 1, "R6");
    chk("R6", "model AND", model[16], 8'h30);

    // page wrap
    wren(); pbuf[0] = 8'h11; pbuf[1] = 8'h22; pbuf[2] = 8'h33;
    program_buf(32'h1FE, 3); clear_busy("R8");
    read_chk(32'h1FE, 3, "R6");
    read_chk(32'h100, 1, "R6");
    chk("R6", "wrapped byte", model[256], 8'h33);

    // four-byte address mode
    simple(8'hB7, "R4"); b_a4 = 1;
    read_chk(32'h0000_0100, 1, "R4");
    wren(); pbuf[0] = 8'h5A; program_buf(32'h0000_0300, 1); clear_busy("R4");
    read_chk(32'h0000_0300, 1, "R4");
    simple(8'hE9, "R4"); b_a4 = 0;
    read_chk(32'h300, 2, "R4");

    // protocol violations
    sel(); put(8'hAB, er); desel(); chk("R12", "unknown opcode err", er, 1);
    sel(); put(8'h05, er); put(8'h00, er); desel(); chk("R12", "byte in status phase", er, 1);
    sel(); take(d, vl, er); desel(); chk("R12", "out_req before opcode", {vl, er}, 2'b01);
    put(8'h9F, er); chk("R12", "byte with select high", er, 1);

    // out of range
    sel(); put(8'h03, er); put_addr(MEM - 1, er);
    take(d, vl, er); chk("R13", "last byte", {er, d}, {1'b0, model[MEM-1]});
    take(d, vl, er); chk("R13", "past end", {er, d}, 9'h100);
    desel();
    wren();
    sel(); put(8'h02, er); put_addr(MEM, er); chk("R13", "program past end err", er, 1);
    put(8'h00, er); desel();
    status_chk(8'h02, "R13");
    erase(8'h20, MEM + 64, er); chk("R13", "erase past end err", er, 1);
    status_chk(8'h02, "R13");
    simple(8'h04, "R2"); m_wel = 0;

    // erase without latch ignored
    erase(8'hD8, 32'h300, er); chk("R7", "no err", er, 0);
    status_chk(8'h00, "R7");
    read_chk(32'h300, 1, "R7");

    // sector erase with busy rejection
    wren(); erase(8'h20, 32'h105, er); chk("R9", "no err", er, 0);
    status_chk(8'h01, "R10");
    sel(); put(8'h02, er); desel(); chk("R10", "program during fill err", er, 1);
    sel(); put(8'h60, er); desel(); chk("R10", "chip erase during fill err", er, 1);
    status_chk(8'h01, "R10");
    repeat (80) @(negedge clk);
    clear_busy("R10");
    read_chk(32'hF8, 80, "R9");

    // 32 and 64 region sizes
    wren(); erase(8'h52, 32'h2C0, er); repeat (150) @(negedge clk); clear_busy("R9");
    read_chk(32'h270, 160, "R9");
    wren(); erase(8'hD8, 32'h350, er); repeat (280) @(negedge clk); clear_busy("R9");
    read_chk(32'h2F0, 32, "R9");
    chk("R9", "0x300 erased", model[12'h300], 8'hFF);

    // random programs and erases
    for (int it = 0; it < 30; it++) begin
      logic [31:0] a; int n;
      if (($urandom % 4) == 0) begin
        b_a4 = !b_a4;
        simple(b_a4 ? 8'hB7 : 8'hE9, "R4");
      end
      a = $urandom % MEM;
      n = 1 + ($urandom % 64);
      for (int k = 0; k < 64; k++) pbuf[k] = 8'($urandom);
      wren(); program_buf(a, n); clear_busy("R8");
      read_chk(a & ~32'hFF, 256, "R6");
      if ((it % 5) == 4) begin
        logic [7:0] op;
        op = (($urandom % 3) == 0) ? 8'h20 : (($urandom % 2) == 0) ? 8'h52 : 8'hD8;
        a = $urandom % MEM;
        wren(); erase(op, a, er); repeat (300) @(negedge clk); clear_busy("R9");
        read_chk(a & ~32'hFF, 256, "R9");
      end
    end
    if (b_a4) begin simple(8'hE9, "R4"); b_a4 = 0; end

    // abort in address phase
    sel(); put(8'h03, er); put(8'h00, er); desel();
    sel(); put(8'h9F, er); take(d, vl, er); desel();
    chk("R14", "opcode after abort", {er, d}, 9'h055);

    // chip erase: without then with latch
    erase(8'h60, 0, er); chk("R7", "chip erase no latch no err", er, 0);
    status_chk(8'h00, "R7");
    read_chk(32'h10, 1, "R7");
    wren(); erase(8'h60, 0, er);
    repeat (MEM + 20) @(negedge clk);
    clear_busy("R9");
    read_chk(32'h0, MEM, "R9");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule